// File: doc/BRIEF.md
# DMA Channel Start and Interrupt Control Slice

This block is the register-facing control slice of a seven-channel DMA controller. It holds one control word per channel, a shared word of per-channel enable bits, and a shared interrupt register. When software writes a channel's control word with the busy bit set and that channel's enable bit is set in the shared word, the block sends a one-cycle start pulse to the channel's transfer engine. The transfer engines themselves, which handle address and block count, are outside this block.

Each engine reports the end of its transfer with a one-cycle done pulse. The done pulse clears the busy bit. If the channel's completion interrupt is enabled, it also latches a per-channel flag. A combined condition built from the flags, a global enable and a force bit drives a single request line toward the system interrupt controller. That line pulses once when the condition becomes true and stays quiet until the condition has gone false and then true again. Software clears a flag by writing a 1 to its bit position.

Channel slot 5 is not populated. Its control word reads as zero, writes to it are discarded, and its done input has no effect.

Top module: `dmac_ctl_slice`

## Requirements
- R1: After reset, every control word and the interrupt register read 0, the enable word reads 0x07654321, and start_o, rearm_o and irq_o are low.
- R2: Register map on the 8-bit byte offset: control word of channel n at 16*n+8, enable word at 0x70, interrupt register at 0x74. Any other offset reads 0, and a write to it changes no register.
- R3: Channel 5 is a hole. Its control word at 0x58 always reads 0, a write there never pulses start_o or rearm_o, and done_i[5] neither sets a flag nor raises irq_o.
- R4: A write to channel n's control word stores the data. start_o[n] is high for exactly the one cycle after that write edge when written bit 24 is 1 and enable-word bit 3+4*n is 1 at the time of the write. Otherwise start_o[n] stays low.
- R5: A control-word write with bit 24 set while the stored bit 24 is already 1 is still accepted and stored, and rearm_o[n] pulses for one cycle after the write edge.
- R6: done_i[n] clears bit 24 of channel n's control word. If the same cycle also writes that word, the written value is stored instead.
- R7: A write to the interrupt register loads bits 0-5, 15 and 16-23 from the data and forces the other bits of 0-23 to 0. It clears each flag bit 24-30 whose written bit is 1 and keeps each flag bit whose written bit is 0. Bit 23 is the global enable, bit 15 the force bit, and bits 16-22 enable completion flags for channels 0-6.
- R8: done_i[n] sets flag bit 24+n when enable bit 16+n is set, judged on the register value after any same-cycle write. A set in the same cycle as a write-1 clear of that flag wins.
- R9: Bit 31 of the interrupt register reads the combined condition: (bit 23 AND any of bits 24-30) OR bit 15.
- R10: irq_o is a one-cycle pulse in the cycle after an edge where the combined condition becomes true while it was false before that edge. No further pulse occurs until the condition has been false at an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| done_i | input | 7 | Per-channel transfer-complete pulses |
| start_o | output | 7 | Per-channel start pulses to the transfer engines |
| rearm_o | output | 7 | Debug pulse: busy bit written while already busy |
| irq_o | output | 1 | Single request pulse toward the interrupt controller |

## Verification
The hardest situation to reach from the ports is a second interrupt request. To get one, the combined condition must first drop, either because every flag is cleared by a write-1 or because the global enable and force bits are dropped, and then rise again through a done pulse or a new force. The reset enable word also blocks every channel, so start pulses cannot appear until the enable word has been rewritten. The stimulus mixes random writes, which set enable bits densely and clear flags often, with random done pulses. Directed sequences cover a clear and a done pulse on the same cycle, repeated busy writes, and hole-channel traffic.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
    parameter int NCH       = 7;
    parameter int HOLE_CH   = 5;
    parameter int DW        = 32;
    parameter int AW        = 8;
    parameter int BUSY_BIT  = 24;
    parameter int FLAG_LSB  = 24;
    parameter int IEN_LSB   = 16;
    parameter int GEN_BIT   = 23;
    parameter int FORCE_BIT = 15;
    parameter logic [DW-1:0] ENA_RESET = 32'h0765_4321;
    parameter logic [DW-1:0] CFG_KEEP  = 32'h00FF_803F;
    parameter logic [AW-1:0] ENA_OFS   = 8'h70;
    parameter logic [AW-1:0] IRQ_OFS   = 8'h74;
    parameter int CTL_STRIDE = 16;
    parameter int CTL_BASE   = 8;

    typedef struct packed {
        logic [DW-1:0] ctl;
        logic          start;
        logic          rearm;
    } chan_state_t;

    typedef struct packed {
        logic [DW-1:0]  cfg;
        logic [NCH-1:0] flags;
        logic           sent;
        logic           pulse;
    } irq_state_t;
endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
    import dmac_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [DW-1:0]      en_word,
    input  logic [NCH-1:0]     done_i,
    output logic [NCH*DW-1:0]  ctl_flat,
    output logic [NCH-1:0]     start_o,
    output logic [NCH-1:0]     rearm_o
);
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        if (n == HOLE_CH) begin : g_hole
            assign ctl_flat[n*DW +: DW] = '0;
            assign start_o[n] = 1'b0;
            assign rearm_o[n] = 1'b0;
        end else begin : g_live
            localparam logic [AW-1:0] MY_OFS = AW'(n*CTL_STRIDE + CTL_BASE);
            localparam int ENA_BIT = 3 + 4*n;
            chan_state_t st_d, st_q;
            logic hit;

            assign hit = wr_en && (wr_addr == MY_OFS);

            always_comb begin
                st_d       = st_q;
                st_d.start = 1'b0;
                st_d.rearm = 1'b0;
                if (done_i[n]) st_d.ctl[BUSY_BIT] = 1'b0;
                if (hit) begin
                    st_d.ctl   = wr_data;
                    st_d.start = wr_data[BUSY_BIT] & en_word[ENA_BIT];
                    st_d.rearm = wr_data[BUSY_BIT] & st_q.ctl[BUSY_BIT];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign ctl_flat[n*DW +: DW] = st_q.ctl;
            assign start_o[n] = st_q.start;
            assign rearm_o[n] = st_q.rearm;

            // R4: a start pulse needs a busy write and the enable bit
            p_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
                start_o[n] |-> $past(hit && wr_data[BUSY_BIT] && en_word[ENA_BIT]));
            // R6: done without a same-cycle write drops busy
            p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (done_i[n] && !hit) |=> !ctl_flat[n*DW + BUSY_BIT]);
            // R5: rearm implies a start request was written
            p_rearm_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
                rearm_o[n] |-> $past(hit && wr_data[BUSY_BIT]));
        end
    end
endmodule

// File: rtl/dmac_irq_reg.sv
module dmac_irq_reg
    import dmac_ctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_hit,
    input  logic [DW-1:0]  wr_data,
    input  logic [NCH-1:0] done_i,
    output logic [DW-1:0]  reg_o,
    output logic           irq_o
);
    localparam logic [NCH-1:0] DONE_LIVE = ~(NCH'(1) << HOLE_CH);

    irq_state_t st_d, st_q;
    logic cond_d, cond_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.cfg   = wr_data & CFG_KEEP;
            st_d.flags = st_q.flags & ~wr_data[FLAG_LSB +: NCH];
        end
        st_d.flags = st_d.flags | (done_i & DONE_LIVE & st_d.cfg[IEN_LSB +: NCH]);
        cond_d     = (st_d.cfg[GEN_BIT] && (|st_d.flags)) || st_d.cfg[FORCE_BIT];
        st_d.pulse = cond_d && !st_q.sent;
        st_d.sent  = cond_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cond_q = (st_q.cfg[GEN_BIT] && (|st_q.flags)) || st_q.cfg[FORCE_BIT];
    assign reg_o  = {cond_q, st_q.flags, st_q.cfg[FLAG_LSB-1:0]};
    assign irq_o  = st_q.pulse;

    // R10: the request never holds for two cycles
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R9: a request is only seen while the condition reads true
    p_irq_cond_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> reg_o[DW-1]);
    // R3: the hole channel alone cannot create a flag
    p_hole_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i == (NCH'(1) << HOLE_CH) && !wr_hit) |=> $stable(reg_o[FLAG_LSB +: NCH]));
endmodule

// File: rtl/dmac_ctl_slice.sv
module dmac_ctl_slice
    import dmac_ctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] done_i,
    output logic [NCH-1:0] start_o,
    output logic [NCH-1:0] rearm_o,
    output logic           irq_o
);
    logic [DW-1:0]     ena_d, ena_q;
    logic [NCH*DW-1:0] ctl_flat;
    logic [DW-1:0]     irq_word;

    always_comb begin
        ena_d = ena_q;
        if (bus_we && bus_addr == ENA_OFS) ena_d = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ena_q <= ENA_RESET;
        else        ena_q <= ena_d;
    end

    dmac_chan_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_we),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .en_word  (ena_q),
        .done_i   (done_i),
        .ctl_flat (ctl_flat),
        .start_o  (start_o),
        .rearm_o  (rearm_o)
    );

    dmac_irq_reg u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (bus_we && bus_addr == IRQ_OFS),
        .wr_data (bus_wdata),
        .done_i  (done_i),
        .reg_o   (irq_word),
        .irq_o   (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ENA_OFS)      bus_rdata = ena_q;
        else if (bus_addr == IRQ_OFS) bus_rdata = irq_word;
        else begin
            for (int n = 0; n < NCH; n++) begin
                if (bus_addr == AW'(n*CTL_STRIDE + CTL_BASE))
                    bus_rdata = ctl_flat[n*DW +: DW];
            end
        end
    end

    // R3: the hole slot always reads zero
    p_hole_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(HOLE_CH*CTL_STRIDE + CTL_BASE)) |-> (bus_rdata == '0));
    // R3: no start or rearm pulse from the hole
    p_hole_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !start_o[HOLE_CH] && !rearm_o[HOLE_CH]);
endmodule

// File: tb/dmac_ctl_slice_bench.sv
module dmac_ctl_slice_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  done_i = '0;
    logic [6:0]  start_o, rearm_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] m_ctl [7];
    logic [31:0] m_en, m_cfg;
    logic [6:0]  m_flags;
    logic        m_sent;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmac_ctl_slice u_dmac_ctl_slice (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_i(done_i),
        .start_o(start_o), .rearm_o(rearm_o), .irq_o(irq_o)
    );

    function automatic logic m_cond(logic [31:0] cfg, logic [6:0] fl);
        return (cfg[23] && (|fl)) || cfg[15];
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a == 8'h70) return m_en;
        if (a == 8'h74) return {m_cond(m_cfg, m_flags), m_flags, m_cfg[23:0]};
        for (int c = 0; c < 7; c++)
            if (a == 8'(c*16 + 8)) return (c == 5) ? 32'h0 : m_ctl[c];
        return 32'h0;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic read_chk(string req, logic [7:0] a);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic [6:0] dn, logic [7:0] ra);
        logic [31:0] n_ctl [7];
        logic [31:0] n_en, n_cfg;
        logic [6:0]  n_fl, e_start, e_rearm;
        logic        cnd, e_irq;
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; done_i = dn;
        e_start = '0; e_rearm = '0;
        for (int c = 0; c < 7; c++) begin
            n_ctl[c] = m_ctl[c];
            if (c != 5) begin
                if (dn[c]) n_ctl[c][24] = 1'b0;
                if (we && a == 8'(c*16 + 8)) begin
                    n_ctl[c] = d;
                    e_start[c] = d[24] & m_en[3 + 4*c];
                    e_rearm[c] = d[24] & m_ctl[c][24];
                end
            end
        end
        n_en  = (we && a == 8'h70) ? d : m_en;
        n_cfg = (we && a == 8'h74) ? (d & 32'h00FF_803F) : m_cfg;
        n_fl  = (we && a == 8'h74) ? (m_flags & ~d[30:24]) : m_flags;
        n_fl  = n_fl | (dn & n_cfg[22:16] & 7'b101_1111);
        cnd   = m_cond(n_cfg, n_fl);
        e_irq = cnd && !m_sent;
        @(posedge clk);
        #1;
        chk("R4 start_o", 32'(start_o), 32'(e_start));
        chk("R5 rearm_o", 32'(rearm_o), 32'(e_rearm));
        chk("R10 irq_o", 32'(irq_o), 32'(e_irq));
        for (int c = 0; c < 7; c++) m_ctl[c] = n_ctl[c];
        m_en = n_en; m_cfg = n_cfg; m_flags = n_fl; m_sent = cnd;
        bus_we = 1'b0; done_i = '0;
        read_chk("R2 readback", ra);
    endtask

    function automatic logic [7:0] rand_addr();
        int k = $urandom_range(0, 11);
        if (k < 7)  return 8'(k*16 + 8);
        if (k < 9)  return 8'h70;
        if (k < 11) return 8'h74;
        return 8'($urandom_range(0, 255));
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 7; c++) m_ctl[c] = '0;
        m_en = 32'h0765_4321; m_cfg = '0; m_flags = '0; m_sent = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset values
        for (int c = 0; c < 7; c++) read_chk("R1 ctl reset", 8'(c*16 + 8));
        read_chk("R1 enable reset", 8'h70);
        read_chk("R1 irq reg reset", 8'h74);
        chk("R1 outputs reset", {start_o, rearm_o, irq_o}, 32'h0);
        // R4: reset enable word blocks every start
        step(1, 8'h08, 32'h0100_0000, 7'h0, 8'h08);
        // R5: second busy write pulses rearm
        step(1, 8'h08, 32'h0100_0001, 7'h0, 8'h08);
        // R2: unmapped write has no effect
        step(1, 8'h7C, 32'hFFFF_FFFF, 7'h0, 8'h7C);
        // R4: enable all and start channel 3
        step(1, 8'h70, 32'hFFFF_FFFF, 7'h0, 8'h70);
        step(1, 8'h38, 32'h0100_0000, 7'h0, 8'h38);
        // R3: hole write and hole done
        step(1, 8'h58, 32'hFFFF_FFFF, 7'h0, 8'h58);
        step(1, 8'h74, 32'h00FF_0000, 7'h0, 8'h74);
        step(0, 8'h00, 32'h0, 7'b010_0000, 8'h74);
        // R8/R10: done sets a flag, request fires once
        step(0, 8'h00, 32'h0, 7'b000_1000, 8'h38);
        step(0, 8'h00, 32'h0, 7'b000_0001, 8'h74);
        // R8: clear and set of the same flag in one cycle
        step(1, 8'h74, 32'h08FF_0000, 7'b000_1000, 8'h74);
        // R7/R10: clear all flags, then rearm by force bit
        step(1, 8'h74, 32'h7FFF_0000, 7'h0, 8'h74);
        step(1, 8'h74, 32'h0000_803F, 7'h0, 8'h74);
        step(1, 8'h74, 32'h0000_0000, 7'h0, 8'h74);
        // R6: write wins over done on the same channel
        step(1, 8'h18, 32'h0100_0000, 7'b000_0010, 8'h18);
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a  = rand_addr();
            logic [31:0] d  = $urandom();
            logic [6:0]  dn = ($urandom_range(0, 3) == 0) ? 7'($urandom()) : 7'h0;
            if ($urandom_range(0, 1) == 1) d[24] = 1'b1;
            if (a == 8'h74 && $urandom_range(0, 2) != 0) d[30:24] = '0;
            step(($urandom_range(0, 2) != 0), a, d, dn, rand_addr());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule